// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Cycle Decoder

This block sits on the memory side of a 256K x 16 asynchronous DRAM interface. It runs from a fast sampling clock. It watches the row strobe, the two byte column strobes, write enable, output enable and the 9-bit multiplexed address bus. Every strobe and address bit passes through a two-flop synchroniser. Edges are then found on the synchronised copies.

From the order of those edges the block classifies each memory cycle. A cycle can be a read, a write, a read-modify-write, a RAS-only refresh or a CAS-before-RAS refresh. For each cycle the block reports the 18-bit word address and an operation code with a one-cycle valid strobe. It also drives per-byte write strobes and per-byte output enables, and it keeps the 9-bit internal refresh row counter.

The two byte column strobes are merged into one internal column strobe. Read output enables persist past the column strobe rising edge, so extended-data-out page accesses keep their data on the bus.

Top module: `dram_cycle_decoder`

## Requirements
- R1: On a row strobe falling edge with both column strobes high, the address bus is taken as the row, `word_addr[17:9]`. On the next internal column strobe falling edge, the address bus is taken as the column, `word_addr[8:0]`.
- R2: The internal column strobe becomes active when the first of the two byte column strobes falls. It becomes inactive only after both are high again. A second byte strobe falling while the first is still low starts no new access.
- R3: With write enable high, a read starts at the later of the internal column strobe fall and the output enable fall. It reports `op_code` 1 and sets `byte_oe` to the low byte lanes. Bit 0 belongs to the lower strobe and data bits 7:0; bit 1 belongs to the upper strobe and data bits 15:8.
- R4: A write starts at the later of the internal column strobe fall and the write enable fall. It reports `op_code` 2 and pulses `byte_we` for one cycle on the low byte lanes, using the same bit-to-lane mapping as R3.
- R5: If write enable falls after a read has started within the same column strobe low period, the block reports `op_code` 3 (read-modify-write) at the same address and pulses `byte_we`.
- R6: In page mode, `byte_oe` stays set after the internal column strobe rises. It clears at the next internal column strobe fall, when output enable goes high, or in standby.
- R7: If any column strobe is low when the row strobe falls, the block reports `op_code` 5 (CAS-before-RAS refresh). The row is taken from the refresh counter and the address bus is ignored. No write strobe is raised. The counter advances by one, wrapping at 9 bits, when that row strobe rises.
- R8: If the row strobe falls and then rises with no column strobe falling in between, the block reports `op_code` 4 (RAS-only refresh) with the externally supplied row when the row strobe rises. The refresh counter is unchanged.
- R9: A hidden refresh keeps `byte_oe` at its read value across the row strobe rise and the refresh. A hidden refresh is a read, followed by the row strobe rising and falling again while the column strobe is held low.
- R10: In standby (row strobe and both column strobes high), `op_code` reads 0 and `byte_oe` is 0.
- R11: `op_valid` is a single-cycle pulse at each operation start. `byte_we` is non-zero only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | 9 | Multiplexed row/column address |
| word_addr | output | 18 | Latched {row, column} word address |
| op_code | output | 3 | Operation code (0 idle, 1 read, 2 write, 3 read-modify-write, 4 RAS-only refresh, 5 CBR refresh) |
| op_valid | output | 1 | One-cycle strobe at an operation start |
| byte_we | output | 2 | Per-byte write strobe, bit 1 upper |
| byte_oe | output | 2 | Per-byte output enable, bit 1 upper |
| refresh_row | output | 9 | Internal refresh row counter |

## Verification
The assertions assume that each strobe moves at most once every few sampling clocks. Under that assumption two operation starts can never fall in adjacent cycles. They also assume the address bus is stable for several clocks around each strobe edge, which is the normal setup and hold on such an interface.

The stimulus follows these rules throughout. It changes one strobe group at a time and waits four clocks after each change, so both synchroniser stages and the edge register have settled before the next move. It sets the address bus before the matching strobe falls and holds it until the strobe has been seen.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_READ     = 3'd1,
        OP_WRITE    = 3'd2,
        OP_RMW      = 3'd3,
        OP_RAS_ONLY = 3'd4,
        OP_CBR      = 3'd5
    } dram_op_e;

    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
            end else begin
                meta_q <= din[b];
                sync_q <= meta_q;
            end
        end
        assign dout[b] = sync_q;
    end
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] row
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign row = cnt_q;
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
    import dram_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n_s,
    input  logic                  lcas_n_s,
    input  logic                  ucas_n_s,
    input  logic                  we_n_s,
    input  logic                  oe_n_s,
    input  logic [ADDR_W-1:0]     addr_s,
    input  logic [ADDR_W-1:0]     ctr_row,
    output logic                  ctr_inc,
    output logic [2*ADDR_W-1:0]   word_addr,
    output dram_op_e              op,
    output logic                  valid,
    output logic [NUM_LANES-1:0]  lane_we,
    output logic [NUM_LANES-1:0]  lane_oe
);
    typedef struct packed {
        logic [ADDR_W-1:0]    row;
        logic [ADDR_W-1:0]    col;
        dram_op_e             op;
        logic                 valid;
        logic [NUM_LANES-1:0] we;
        logic [NUM_LANES-1:0] oe;
        logic                 in_cbr;
        logic                 pend_ro;
        logic                 rd_done;
        logic                 wr_done;
        logic                 p_ras_n;
        logic                 p_cas;
        logic                 p_we_n;
        logic                 p_oe_n;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    inc_d;

    logic                 cas_on;
    logic [NUM_LANES-1:0] lanes;
    logic                 ras_fall, ras_rise, cas_fall, we_fall, oe_fall;

    always_comb begin
        lanes    = {~ucas_n_s, ~lcas_n_s};
        cas_on   = |lanes;
        ras_fall = st_q.p_ras_n & ~ras_n_s;
        ras_rise = ~st_q.p_ras_n & ras_n_s;
        cas_fall = ~st_q.p_cas & cas_on;
        we_fall  = st_q.p_we_n & ~we_n_s;
        oe_fall  = st_q.p_oe_n & ~oe_n_s;

        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.we      = '0;
        st_d.p_ras_n = ras_n_s;
        st_d.p_cas   = cas_on;
        st_d.p_we_n  = we_n_s;
        st_d.p_oe_n  = oe_n_s;
        inc_d        = 1'b0;

        if (ras_fall) begin
            if (cas_on) begin
                st_d.in_cbr  = 1'b1;
                st_d.row     = ctr_row;
                st_d.op      = OP_CBR;
                st_d.valid   = 1'b1;
                st_d.pend_ro = 1'b0;
            end else begin
                st_d.in_cbr  = 1'b0;
                st_d.row     = addr_s;
                st_d.pend_ro = 1'b1;
                st_d.rd_done = 1'b0;
                st_d.wr_done = 1'b0;
            end
        end else if (ras_rise) begin
            if (st_q.in_cbr) begin
                inc_d       = 1'b1;
                st_d.in_cbr = 1'b0;
            end else if (st_q.pend_ro) begin
                st_d.op      = OP_RAS_ONLY;
                st_d.valid   = 1'b1;
                st_d.pend_ro = 1'b0;
            end
        end else if (!ras_n_s && !st_q.in_cbr) begin
            if (cas_fall) begin
                st_d.col     = addr_s;
                st_d.pend_ro = 1'b0;
                st_d.oe      = '0;
                st_d.rd_done = 1'b0;
                st_d.wr_done = 1'b0;
                if (!we_n_s) begin
                    st_d.op      = OP_WRITE;
                    st_d.valid   = 1'b1;
                    st_d.we      = lanes;
                    st_d.wr_done = 1'b1;
                end else if (!oe_n_s) begin
                    st_d.op      = OP_READ;
                    st_d.valid   = 1'b1;
                    st_d.oe      = lanes;
                    st_d.rd_done = 1'b1;
                end
            end else if (cas_on) begin
                if (we_fall && !st_q.wr_done) begin
                    st_d.op      = st_q.rd_done ? OP_RMW : OP_WRITE;
                    st_d.valid   = 1'b1;
                    st_d.we      = lanes;
                    st_d.wr_done = 1'b1;
                end else if (oe_fall && we_n_s && !st_q.rd_done) begin
                    st_d.op      = OP_READ;
                    st_d.valid   = 1'b1;
                    st_d.oe      = lanes;
                    st_d.rd_done = 1'b1;
                end
            end
        end

        if (oe_n_s) st_d.oe = '0;
        if (ras_n_s && !cas_on) begin
            st_d.oe = '0;
            if (!st_d.valid) st_d.op = OP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.op      <= OP_IDLE;
            st_q.p_ras_n <= 1'b1;
            st_q.p_we_n  <= 1'b1;
            st_q.p_oe_n  <= 1'b1;
            ctr_inc      <= 1'b0;
        end else begin
            st_q    <= st_d;
            ctr_inc <= inc_d;
        end
    end

    assign word_addr = {st_q.row, st_q.col};
    assign op        = st_q.op;
    assign valid     = st_q.valid;
    assign lane_we   = st_q.we;
    assign lane_oe   = st_q.oe;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dram_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_n,
    input  logic                 lcas_n,
    input  logic                 ucas_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic [2*ADDR_W-1:0]  word_addr,
    output logic [2:0]           op_code,
    output logic                 op_valid,
    output logic [1:0]           byte_we,
    output logic [1:0]           byte_oe,
    output logic [ADDR_W-1:0]    refresh_row
);
    localparam int unsigned NSTB = 5;
    localparam int unsigned SW   = NSTB + ADDR_W;
    localparam logic [SW-1:0] SYNC_RST = {{NSTB{1'b1}}, {ADDR_W{1'b0}}};

    logic [SW-1:0]     sync_in, sync_out;
    logic [ADDR_W-1:0] ctr_row;
    logic              ctr_inc;
    dram_op_e          op;

    assign sync_in = {ras_n, lcas_n, ucas_n, we_n, oe_n, addr_in};

    dram_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    dram_refresh_ctr #(.W(ADDR_W)) i_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ctr_inc),
        .row  (ctr_row)
    );

    dram_cycle_fsm #(.ADDR_W(ADDR_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n_s  (sync_out[SW-1]),
        .lcas_n_s (sync_out[SW-2]),
        .ucas_n_s (sync_out[SW-3]),
        .we_n_s   (sync_out[SW-4]),
        .oe_n_s   (sync_out[SW-5]),
        .addr_s   (sync_out[ADDR_W-1:0]),
        .ctr_row  (ctr_row),
        .ctr_inc  (ctr_inc),
        .word_addr(word_addr),
        .op       (op),
        .valid    (op_valid),
        .lane_we  (byte_we),
        .lane_oe  (byte_oe)
    );

    assign op_code     = op;
    assign refresh_row = ctr_row;
endmodule

module dram_cycle_decoder_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          op_code,
    input logic                op_valid,
    input logic [1:0]          byte_we,
    input logic [ADDR_W-1:0]   refresh_row
);
    a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    a_r11_we_only_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we != 2'b00) |-> op_valid);

    a_r4_we_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we != 2'b00) |-> (op_code == 3'd2 || op_code == 3'd3));

    a_r7_cbr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |-> (byte_we == 2'b00));

    a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_row) |-> (refresh_row == ADDR_W'($past(refresh_row) + 1'b1)));

    a_r11_valid_op_known: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_code != 3'd0 && op_code <= 3'd5));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .op_valid   (op_valid),
    .byte_we    (byte_we),
    .refresh_row(refresh_row)
);

// File: tb/test_dram_cycle_decoder.sv
module test_dram_cycle_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0] addr_in = '0;
    logic [17:0] word_addr;
    logic [2:0] op_code;
    logic       op_valid;
    logic [1:0] byte_we, byte_oe;
    logic [8:0] refresh_row;

    typedef struct {
        logic [2:0]  op;
        logic [17:0] addr;
        logic [1:0]  we;
        bit          row_only;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    bit   prev_valid = 0;

    always #10 clk = ~clk;

    dram_cycle_decoder i_dram_cycle_decoder (.*);

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [2:0] op, input logic [8:0] row, input logic [8:0] col,
                        input logic [1:0] we, input bit ro, input string req);
        exp_t e;
        e.op = op; e.addr = {row, col}; e.we = we; e.row_only = ro; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (op_valid && prev_valid) begin
                n_cmp++; n_bad++;
                $display("FAIL R11: actual valid width 2 expected 1");
            end
            if (op_valid) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2: actual unexpected op %0d expected none", op_code);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    n_cmp++;
                    if (op_code !== e.op || byte_we !== e.we ||
                        (e.row_only ? (word_addr[17:9] !== e.addr[17:9]) : (word_addr !== e.addr))) begin
                        n_bad++;
                        $display("FAIL %s: actual op %0d addr %h we %b expected op %0d addr %h we %b",
                                 e.req, op_code, word_addr, byte_we, e.op, e.addr, e.we);
                    end
                end
            end
            prev_valid = op_valid;
        end
    end

    initial begin
        tick(200000 - 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R10 reset and standby state
        chk("R10 op", 18'(op_code), 18'd0);
        chk("R10 oe", 18'(byte_oe), 18'd0);
        chk("R11 we", 18'(byte_we), 18'd0);
        chk("R7 counter", 18'(refresh_row), 18'd0);

        // R1 R3 word read, then page-mode R6 and byte read
        oe_n = 0; addr_in = 9'h12A; tick(4);
        ras_n = 0; tick(4);
        addr_in = 9'h055; tick(4);
        push(3'd1, 9'h12A, 9'h055, 2'b00, 0, "R1 R3 word read");
        lcas_n = 0; ucas_n = 0; tick(5);
        chk("R3 oe word", 18'(byte_oe), 18'd3);
        lcas_n = 1; ucas_n = 1; tick(5);
        chk("R6 oe held after CAS rise", 18'(byte_oe), 18'd3);
        addr_in = 9'h0F0; tick(4);
        push(3'd1, 9'h12A, 9'h0F0, 2'b00, 0, "R3 lower byte read");
        lcas_n = 0; tick(5);
        chk("R3 oe lower", 18'(byte_oe), 18'd1);
        // R2: second byte strobe falls while first low, no new access
        ucas_n = 0; tick(5);
        chk("R2 oe unchanged", 18'(byte_oe), 18'd1);
        lcas_n = 1; tick(5);
        chk("R2 oe still lower", 18'(byte_oe), 18'd1);
        ucas_n = 1; tick(4);
        oe_n = 1; tick(5);
        chk("R6 oe cleared by OE high", 18'(byte_oe), 18'd0);
        oe_n = 0; tick(4);
        push(3'd1, 9'h12A, 9'h033, 2'b00, 0, "R6 page read");
        addr_in = 9'h033; tick(4);
        ucas_n = 0; tick(5);
        chk("R3 oe upper", 18'(byte_oe), 18'd2);
        ucas_n = 1; tick(4);
        ras_n = 1; tick(5);
        chk("R10 standby oe", 18'(byte_oe), 18'd0);
        chk("R10 standby op", 18'(op_code), 18'd0);

        // R4 early upper-byte write
        oe_n = 1; we_n = 0; addr_in = 9'h001; tick(4);
        ras_n = 0; tick(4);
        addr_in = 9'h1FF; tick(4);
        push(3'd2, 9'h001, 9'h1FF, 2'b10, 0, "R4 early upper write");
        ucas_n = 0; tick(5);
        ucas_n = 1; tick(4);
        we_n = 1; tick(4);
        // R4 late word write
        addr_in = 9'h0AB; tick(4);
        lcas_n = 0; ucas_n = 0; tick(5);
        push(3'd2, 9'h001, 9'h0AB, 2'b11, 0, "R4 late word write");
        we_n = 0; tick(5);
        we_n = 1; lcas_n = 1; ucas_n = 1; tick(5);
        // R3 late OE read
        addr_in = 9'h111; tick(4);
        lcas_n = 0; ucas_n = 0; tick(5);
        chk("R3 no read before OE", 18'(byte_oe), 18'd0);
        push(3'd1, 9'h001, 9'h111, 2'b00, 0, "R3 OE-late read");
        oe_n = 0; tick(5);
        chk("R3 oe after late OE", 18'(byte_oe), 18'd3);
        // R5 read-modify-write within same CAS low
        push(3'd3, 9'h001, 9'h111, 2'b11, 0, "R5 read-modify-write");
        we_n = 0; tick(5);
        oe_n = 1; we_n = 1; tick(4);
        lcas_n = 1; ucas_n = 1; tick(4);
        ras_n = 1; tick(5);

        // R7 CBR refresh, address ignored
        addr_in = 9'h0AA; tick(4);
        lcas_n = 0; tick(4);
        push(3'd5, 9'h000, 9'h000, 2'b00, 1, "R7 CBR row 0");
        ras_n = 0; tick(5);
        chk("R7 oe off in CBR", 18'(byte_oe), 18'd0);
        ras_n = 1; tick(5);
        chk("R7 counter step 1", 18'(refresh_row), 18'd1);
        lcas_n = 1; tick(4);
        ucas_n = 0; tick(4);
        push(3'd5, 9'h001, 9'h000, 2'b00, 1, "R7 CBR row 1");
        ras_n = 0; tick(5);
        ras_n = 1; tick(5);
        ucas_n = 1; tick(4);
        chk("R7 counter step 2", 18'(refresh_row), 18'd2);

        // R8 RAS-only refresh
        addr_in = 9'h0C3; tick(4);
        ras_n = 0; tick(5);
        push(3'd4, 9'h0C3, 9'h000, 2'b00, 1, "R8 RAS-only");
        ras_n = 1; tick(5);
        chk("R8 counter unchanged", 18'(refresh_row), 18'd2);

        // R9 hidden refresh
        oe_n = 0; addr_in = 9'h010; tick(4);
        ras_n = 0; tick(4);
        addr_in = 9'h020; tick(4);
        push(3'd1, 9'h010, 9'h020, 2'b00, 0, "R9 read before hidden refresh");
        lcas_n = 0; ucas_n = 0; tick(5);
        ras_n = 1; tick(5);
        chk("R9 oe across RAS rise", 18'(byte_oe), 18'd3);
        push(3'd5, 9'h002, 9'h000, 2'b00, 1, "R9 hidden CBR");
        ras_n = 0; tick(5);
        chk("R9 oe during hidden refresh", 18'(byte_oe), 18'd3);
        ras_n = 1; tick(5);
        chk("R9 counter step", 18'(refresh_row), 18'd3);
        lcas_n = 1; ucas_n = 1; tick(5);
        chk("R10 oe at end", 18'(byte_oe), 18'd0);
        oe_n = 1; tick(5);

        chk("R11 all expected ops seen", 18'(exp_q.size()), 18'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule